// File: doc/BRIEF.md
# Threshold Motion Overlay

This block sits in the display pixel clock domain of a small video pipeline and marks moving regions on screen. On every pixel clock it receives the current camera pixel and two candidate reference pixels in 5-6-5 RGB form: one from a stored background frame and one from the previous frame. A mode input picks which of the two is used. The block turns the current pixel and the chosen reference into 8-bit grey values and takes the absolute difference between them. It flags motion when that difference is strictly larger than a threshold.

The screen is split into two halves by the horizontal pixel counter. The left half shows the camera image, and any pixel with motion is painted a fixed red. The right half shows the thresholded difference as white (motion) or black (no motion). The selected 16-bit value is widened to 24-bit RGB by repeating the top bits of each field. Outside the visible area the outputs are forced to zero. The block is a two-stage pipeline with no handshake. At the usual 640x480 resolution it runs at a 25 MHz pixel clock.

Top module: `motion_overlay`

## Requirements
- R1: While reset is held and in the first cycle after it, all three colour outputs are zero.
- R2: A pixel is visible only when `active` is high, `hcount` < 640 and `vcount` < 480. For any other pixel all colour outputs are zero.
- R3: The grey value of a pixel is (2·R8 + 5·G8 + B8) / 8, rounded down, where R8, G8 and B8 are the widened fields (see R8). Motion is flagged only when |grey(current) − grey(reference)| is strictly greater than `thresh`. A difference equal to `thresh` is not motion.
- R4: With `mode` = 0 the reference is `bg_pix` (background subtraction). With `mode` = 1 the reference is `prev_pix` (frame difference). The pixel that is not selected has no effect on the output.
- R5: In the left half (`hcount` < 320), a visible pixel with motion is shown as the 16-bit value 0xF100, which widens to 24'hF72000.
- R6: In the left half, a visible pixel without motion is shown as the widened current pixel.
- R7: In the right half (`hcount` ≥ 320), a visible pixel shows 24'hFFFFFF when motion is flagged and 24'h000000 when it is not.
- R8: The 5-6-5 field layout is red in bits 15:11, green in bits 10:5 and blue in bits 4:0. Widening concatenates red {15:11, 15:13}, green {10:5, 10:9} and blue {4:0, 4:2}.
- R9: The outputs for a set of inputs appear two clock cycles after those inputs are sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode | input | 1 | 0: use the background reference, 1: use the previous-frame reference |
| thresh | input | 8 | Motion threshold on the grey difference |
| cur_pix | input | 16 | Current-frame pixel, RGB 5-6-5 |
| bg_pix | input | 16 | Background-frame pixel, RGB 5-6-5 |
| prev_pix | input | 16 | Previous-frame pixel, RGB 5-6-5 |
| hcount | input | 10 | Horizontal pixel counter |
| vcount | input | 10 | Vertical pixel counter |
| active | input | 1 | Active display area flag |
| red_o | output | 8 | Red output |
| green_o | output | 8 | Green output |
| blue_o | output | 8 | Blue output |

## Verification
The port assertions compare the outputs with the inputs sampled two cycles earlier. They therefore assume that reset was released at least two cycles before, and that the inputs were genuine pixels rather than reset-time values. To meet this, the stimulus holds `active` low through reset and for two cycles after it. The bench then drives a new set of inputs on each falling edge. It mixes random pixels with pixels built to hit an exact threshold, and in those constructed cases it makes the two reference inputs differ, so a wrong selection shows at the output.

// File: rtl/motion_overlay_pkg.sv
package motion_overlay_pkg;

   localparam int PIX_W = 16;

   typedef logic [PIX_W-1:0] pix565_t;

   typedef struct packed {
      logic [7:0] r;
      logic [7:0] g;
      logic [7:0] b;
   } rgb888_t;

   // Widen each field by repeating its most significant bits.
   function automatic rgb888_t widen565(input pix565_t p);
      rgb888_t o;
      o.r = {p[15:11], p[15:13]};
      o.g = {p[10:5],  p[10:9]};
      o.b = {p[4:0],   p[4:2]};
      return o;
   endfunction

endpackage

// File: rtl/mo_grey.sv
module mo_grey
   import motion_overlay_pkg::*;
#(
   parameter int GREY_W = 8
) (
   input  pix565_t            pix,
   output logic [GREY_W-1:0]  grey
);
   localparam int SUM_W = GREY_W + 3;

   if (GREY_W != 8) begin : g_bad_width
      $error("mo_grey: GREY_W must be 8");
   end

   rgb888_t            wide;
   logic [SUM_W-1:0]   wsum;

   always_comb begin
      wide = widen565(pix);
      wsum = SUM_W'(wide.r) * SUM_W'(2)
           + SUM_W'(wide.g) * SUM_W'(5)
           + SUM_W'(wide.b);
      grey = wsum[SUM_W-1:3];
   end
endmodule

// File: rtl/mo_thresh_cmp.sv
module mo_thresh_cmp #(
   parameter int GREY_W = 8
) (
   input  logic [GREY_W-1:0] grey_a,
   input  logic [GREY_W-1:0] grey_b,
   input  logic [GREY_W-1:0] limit,
   output logic              moved
);
   logic [GREY_W-1:0] delta;

   always_comb begin
      delta = (grey_a >= grey_b) ? (grey_a - grey_b) : (grey_b - grey_a);
      moved = (delta > limit);
   end
endmodule

// File: rtl/mo_expand.sv
module mo_expand
   import motion_overlay_pkg::*;
(
   input  pix565_t pix,
   output rgb888_t rgb
);
   always_comb rgb = widen565(pix);
endmodule

// File: rtl/motion_overlay.sv
module motion_overlay
   import motion_overlay_pkg::*;
#(
   parameter int          CNT_W    = 10,
   parameter int          H_ACTIVE = 640,
   parameter int          V_ACTIVE = 480,
   parameter int          GREY_W   = 8,
   parameter logic [15:0] MARK_PIX = 16'hF100
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode,
   input  logic [GREY_W-1:0] thresh,
   input  logic [15:0]       cur_pix,
   input  logic [15:0]       bg_pix,
   input  logic [15:0]       prev_pix,
   input  logic [CNT_W-1:0]  hcount,
   input  logic [CNT_W-1:0]  vcount,
   input  logic              active,
   output logic [7:0]        red_o,
   output logic [7:0]        green_o,
   output logic [7:0]        blue_o
);
   localparam logic [CNT_W-1:0] H_LIM  = CNT_W'(H_ACTIVE);
   localparam logic [CNT_W-1:0] V_LIM  = CNT_W'(V_ACTIVE);
   localparam logic [CNT_W-1:0] H_HALF = CNT_W'(H_ACTIVE / 2);
   localparam int               NSRC   = 2;

   if (H_ACTIVE >= (1 << CNT_W) || V_ACTIVE >= (1 << CNT_W)) begin : g_bad_cnt
      $error("motion_overlay: CNT_W too narrow for the display size");
   end
   if (H_ACTIVE < 2) begin : g_bad_h
      $error("motion_overlay: H_ACTIVE too small");
   end

   // ---------------- stage 0: selection and grey conversion ----------------
   pix565_t           ref_sel;
   logic              show_in;
   logic              right_in;
   pix565_t           src   [NSRC];
   logic [GREY_W-1:0] grey_c[NSRC];

   always_comb begin
      ref_sel  = mode ? prev_pix : bg_pix;
      show_in  = active && (hcount < H_LIM) && (vcount < V_LIM);
      right_in = (hcount >= H_HALF);
      src[0]   = cur_pix;
      src[1]   = ref_sel;
   end

   for (genvar k = 0; k < NSRC; k++) begin : g_grey
      mo_grey #(.GREY_W(GREY_W)) u_grey (
         .pix  (src[k]),
         .grey (grey_c[k])
      );
   end

   // ---------------- stage 1 registers ----------------
   logic [GREY_W-1:0] grey_cur_q, grey_ref_q, thresh_q;
   pix565_t           cur_q;
   logic              show_q, right_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         grey_cur_q <= '0;
         grey_ref_q <= '0;
         thresh_q   <= '0;
         cur_q      <= '0;
         show_q     <= 1'b0;
         right_q    <= 1'b0;
      end else begin
         grey_cur_q <= grey_c[0];
         grey_ref_q <= grey_c[1];
         thresh_q   <= thresh;
         cur_q      <= cur_pix;
         show_q     <= show_in;
         right_q    <= right_in;
      end
   end

   // ---------------- stage 1: compare, overlay, widen ----------------
   logic    moved;
   pix565_t shown;
   rgb888_t wide;

   mo_thresh_cmp #(.GREY_W(GREY_W)) u_cmp (
      .grey_a (grey_cur_q),
      .grey_b (grey_ref_q),
      .limit  (thresh_q),
      .moved  (moved)
   );

   always_comb begin
      if (right_q) shown = moved ? 16'hFFFF : 16'h0000;
      else         shown = moved ? MARK_PIX : cur_q;
   end

   mo_expand u_exp (
      .pix (shown),
      .rgb (wide)
   );

   // ---------------- stage 2 registers ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         red_o   <= '0;
         green_o <= '0;
         blue_o  <= '0;
      end else if (show_q) begin
         red_o   <= wide.r;
         green_o <= wide.g;
         blue_o  <= wide.b;
      end else begin
         red_o   <= '0;
         green_o <= '0;
         blue_o  <= '0;
      end
   end

   // ---------------- assertions ----------------
   // R2
   blank_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(rst_n, 2) && !$past(show_in, 2))
      |-> ({red_o, green_o, blue_o} == 24'h0));

   // R7
   right_bw_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(rst_n, 2) && $past(show_in, 2) && $past(right_in, 2))
      |-> ({red_o, green_o, blue_o} == 24'hFFFFFF || {red_o, green_o, blue_o} == 24'h0));

   // R6
   left_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(rst_n, 2) && $past(show_in, 2) && !$past(right_in, 2)
       && ($past(cur_pix, 2) == $past(ref_sel, 2)))
      |-> ({red_o, green_o, blue_o} == 24'(widen565($past(cur_pix, 2)))));

   // R5
   left_red_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(rst_n, 2) && $past(show_in, 2) && !$past(right_in, 2)
       && ({red_o, green_o, blue_o} != 24'(widen565($past(cur_pix, 2)))))
      |-> ({red_o, green_o, blue_o} == 24'(widen565(MARK_PIX))));

endmodule

// File: tb/motion_overlay_test.sv
module motion_overlay_test;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        mode;
   logic [7:0]  thresh;
   logic [15:0] cur_pix, bg_pix, prev_pix;
   logic [9:0]  hcount, vcount;
   logic        active;
   logic [7:0]  red_o, green_o, blue_o;

   int checks = 0;
   int fails  = 0;

   logic [23:0] exp_q[$];
   string       tag_q[$];

   always #5 clk = ~clk;

   motion_overlay uut (
      .clk(clk), .rst_n(rst_n), .mode(mode), .thresh(thresh),
      .cur_pix(cur_pix), .bg_pix(bg_pix), .prev_pix(prev_pix),
      .hcount(hcount), .vcount(vcount), .active(active),
      .red_o(red_o), .green_o(green_o), .blue_o(blue_o)
   );

   // ---- behavioural reference ----
   function automatic int w_r(input logic [15:0] p);
      int v = (p >> 11) & 31; return v * 8 + v / 4;
   endfunction
   function automatic int w_g(input logic [15:0] p);
      int v = (p >> 5) & 63;  return v * 4 + v / 16;
   endfunction
   function automatic int w_b(input logic [15:0] p);
      int v = p & 31;         return v * 8 + v / 4;
   endfunction
   function automatic logic [23:0] wide24(input logic [15:0] p);
      return {8'(w_r(p)), 8'(w_g(p)), 8'(w_b(p))};
   endfunction
   function automatic int grey_of(input logic [15:0] p);
      return (2 * w_r(p) + 5 * w_g(p) + w_b(p)) / 8;
   endfunction

   function automatic logic [23:0] model(input logic m, input int thr,
         input logic [15:0] c, input logic [15:0] bg, input logic [15:0] pv,
         input int h, input int v, input logic act);
      int  d;
      bit  mv;
      d  = grey_of(c) - grey_of(m ? pv : bg);
      if (d < 0) d = -d;
      mv = (d > thr);
      if (!(act && h < 640 && v < 480)) return 24'h0;
      if (h >= 320) return mv ? 24'hFFFFFF : 24'h0;
      return mv ? 24'hF72000 : wide24(c);
   endfunction

   task automatic check(input logic [23:0] got, input logic [23:0] want, input string tag);
      checks++;
      if (got !== want) begin
         fails++;
         $display("FAIL %s: got %h expected %h", tag, got, want);
      end
   endtask

   // One pixel per cycle: check the result due now (R9), then drive the next inputs.
   task automatic step(input logic m, input int thr, input logic [15:0] c,
         input logic [15:0] bg, input logic [15:0] pv, input int h, input int v,
         input logic act, input string tag);
      @(negedge clk);
      if (exp_q.size() == 2) check({red_o, green_o, blue_o}, exp_q.pop_front(), tag_q.pop_front());
      mode = m; thresh = 8'(thr); cur_pix = c; bg_pix = bg; prev_pix = pv;
      hcount = 10'(h); vcount = 10'(v); active = act;
      exp_q.push_back(model(m, thr, c, bg, pv, h, v, act));
      tag_q.push_back({tag, " R9"});
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 700, 0, 0, "R2 idle");
   endtask

   // watchdog
   initial begin
      #1_500_000;
      fails++; checks++;
      $display("FAIL R9 watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      rst_n = 1'b0; mode = 0; thresh = 0; cur_pix = 0; bg_pix = 0; prev_pix = 0;
      hcount = 0; vcount = 0; active = 0;
      repeat (4) @(negedge clk);
      check({red_o, green_o, blue_o}, 24'h0, "R1 during reset");
      rst_n = 1'b1;
      @(negedge clk);
      check({red_o, green_o, blue_o}, 24'h0, "R1 after reset");
      idle(2);

      // R8 / R6: widening with zero difference, left half
      step(0, 10, 16'hF800, 16'hF800, 16'h0000, 5, 5, 1, "R8 red field");
      step(0, 10, 16'h07E0, 16'h07E0, 16'h0000, 6, 5, 1, "R8 green field");
      step(0, 10, 16'h001F, 16'h001F, 16'h0000, 7, 5, 1, "R8 blue field");
      step(1, 10, 16'hA5A5, 16'h0000, 16'hA5A5, 8, 5, 1, "R6 same pixel");
      // R5: motion in left half
      step(0, 10, 16'hFFFF, 16'h0000, 16'hFFFF, 9, 5, 1, "R5 red mark");
      // R7: right half both ways
      step(0, 10, 16'hFFFF, 16'h0000, 16'hFFFF, 400, 5, 1, "R7 white");
      step(1, 10, 16'hFFFF, 16'h0000, 16'hFFFF, 400, 5, 1, "R7 black");
      step(0, 10, 16'h1234, 16'h1234, 16'h0000, 320, 5, 1, "R7 black edge");
      step(0, 10, 16'hFFFF, 16'h0000, 16'h0000, 319, 5, 1, "R5 left edge");
      // R2: blanking
      step(0, 0, 16'hFFFF, 16'h0000, 16'h0000, 10, 5, 0, "R2 inactive");
      step(0, 0, 16'hFFFF, 16'h0000, 16'h0000, 640, 5, 1, "R2 h range");
      step(0, 0, 16'hFFFF, 16'h0000, 16'h0000, 10, 480, 1, "R2 v range");
      // R4: unselected reference has no effect
      step(0, 5, 16'h8410, 16'h8410, 16'hFFFF, 20, 7, 1, "R4 bg selected");
      step(1, 5, 16'h8410, 16'hFFFF, 16'h8410, 21, 7, 1, "R4 prev selected");
      step(0, 5, 16'h8410, 16'hFFFF, 16'h8410, 22, 7, 1, "R4 bg differs");

      // R3: threshold boundary on random pixels
      for (int i = 0; i < 600; i++) begin
         logic [15:0] c, r, o;
         int d, h;
         logic m;
         c = 16'($urandom); r = 16'($urandom); o = ~r;
         m = 1'($urandom);
         d = grey_of(c) - grey_of(r); if (d < 0) d = -d;
         h = (i % 2 == 0) ? (i % 320) : 320 + (i % 320);
         if (d > 0) begin
            step(m, d, c, m ? o : r, m ? r : o, h, 1, 1, "R3 diff equals thresh");
            step(m, d - 1, c, m ? o : r, m ? r : o, h, 1, 1, "R3 diff above thresh");
         end else begin
            step(m, 0, c, m ? o : r, m ? r : o, h, 1, 1, "R3 zero diff");
         end
      end

      // mixed random traffic
      for (int i = 0; i < 1500; i++) begin
         step(1'($urandom), int'($urandom_range(0, 255)), 16'($urandom), 16'($urandom),
              16'($urandom), int'($urandom_range(0, 700)), int'($urandom_range(0, 520)),
              1'($urandom_range(0, 7) != 0), "R6 R7 random");
      end

      idle(3);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule